// File: doc/BRIEF.md
# Deferred Status-Flag Evaluator

This block turns a record of the last flag-setting operation into an updated status word. The record is an operation class, an operand width, the two operands, the result, the upper half of a product, a per-operation write mask, the extended-arithmetic state and the current status word. Flags are computed only when something needs them. The execution pipeline keeps the record and presents it here. One clock later, the block returns the status word with the condition bits refreshed.

Carry and overflow come only from the top bits of the two operands and the result at the selected width. Subtract-type operations invert the source operand before evaluation and invert the carry afterwards. The multiply-carry class writes its carry into a separate status position (parameter `R_POS`). The two multiply classes evaluate the 64-bit product. The move/logic/shift class reports only sign and zero. The write merge honours a mask and an extended-arithmetic rule that keeps the zero flag sticky across chained operations.

Top module: `ccf_eval`

## Requirements
- R1: While `rst_ni` is low, `ccs_o` is zero. After reset, `ccs_o` in each cycle is the evaluation of the inputs present at the previous rising clock edge.
- R2: For an arithmetic class, with s, d and r the top bits of source, destination and result at the operand width: if r=1, N is set, V is set when s=0 and d=0, and otherwise C is set when s=1 and d=1. Op codes: 0 = add-type, 1 = subtract, 2 = compare, 3 = multiply-carry, 4 = signed multiply, 5 = unsigned multiply, 6 = move/logic/shift, 7 = flags already live.
- R3: For an arithmetic class with r=0: Z is set when the result is zero at the operand width, V is set when s=1 and d=1, and C is set when s=1 or d=1.
- R4: Size code 0 selects 8 bits (top bit 7), code 1 selects 16 bits (bit 15) and code 2 selects 32 bits (bit 31). Bits above the width are ignored. With code 3 no flag is produced, except the inverted carry of R5.
- R5: Ops 1 and 2 evaluate R2/R3 with the source bitwise inverted, and then invert C.
- R6: Op 3 applies R2/R3 at 32 bits whatever the size code, and writes the carry-position result to bit `R_POS` (default 8) instead of bit 0.
- R7: Op 4 forms {hi,res}. It sets Z if this is zero, otherwise N from bit 63. It sets V when hi differs from the sign extension of res. C is produced as 0.
- R8: Op 5 sets Z and N like R7, and sets V when hi is nonzero. C is produced as 0.
- R9: Op 6 at 16 or 32 bits sets N from the top result bit, or else Z if the result is zero, and produces V=C=0. At 8 bits it uses R2/R3.
- R10: Status bits are C=0, V=1, Z=2, N=3, X=4. The write mask is `mask_i` with bit 4 forced on. Masked bits take the new value and all other bits keep `ccs_i`, so X is always cleared.
- R11: When `x_i` is 1 and the new Z is 1, bit 2 is removed from the write mask, so a previous Z=0 is kept.
- R12: Op 7 returns `ccs_i` unchanged, X included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation class code |
| size_i | input | 2 | Operand width code |
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination operand |
| res_i | input | DATA_W | Result (low product word for multiplies) |
| hi_i | input | DATA_W | High product word |
| mask_i | input | STAT_W | Per-operation writable-flag mask |
| x_i | input | 1 | Extended-arithmetic state |
| ccs_i | input | STAT_W | Current status word |
| ccs_o | output | STAT_W | Updated status word, one cycle later |

## Verification
Several corner cases are covered by directed tests. Sign bits are placed above the selected width: a design that reads bit 31 for byte work would report N and V wrongly. Subtractions with equal operands expose a missing source inversion or carry inversion, which flips C. Signed products whose high word is all ones with a negative low word separate true overflow from plain sign extension. In extended mode a zero result tests the sticky zero: a design that gets it wrong sets Z where the old value was 0. Random vectors cover every class at every width, and the expected words come from an independent model of the requirements.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    localparam int C_POS = 0;
    localparam int V_POS = 1;
    localparam int Z_POS = 2;
    localparam int N_POS = 3;
    localparam int X_POS = 4;

    localparam int NLANE = 3;

    typedef enum logic [2:0] {
        OPC_ALU   = 3'd0,
        OPC_SUB   = 3'd1,
        OPC_CMP   = 3'd2,
        OPC_MCP   = 3'd3,
        OPC_MULS  = 3'd4,
        OPC_MULU  = 3'd5,
        OPC_LOGIC = 3'd6,
        OPC_LIVE  = 3'd7
    } ccf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } ccf_size_e;

    // carry slot also carries the multiply-carry result
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_flags_t;

endpackage

// File: rtl/ccf_lane_view.sv
module ccf_lane_view
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ccf_size_e         size_i,
    input  logic [NLANE-1:0]  src_sg_i,
    input  logic [NLANE-1:0]  dst_sg_i,
    input  logic [DATA_W-1:0] res_i,
    output logic              s_o,
    output logic              d_o,
    output logic              r_o,
    output logic              zero_o,
    output logic              known_o
);
    logic [NLANE-1:0] res_sg;
    logic [NLANE-1:0] res_zero;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = ((8 << g) > DATA_W) ? DATA_W : (8 << g);
        assign res_sg[g]   = res_i[LW-1];
        assign res_zero[g] = ~|res_i[LW-1:0];
    end

    always_comb begin
        s_o     = 1'b0;
        d_o     = 1'b0;
        r_o     = 1'b0;
        zero_o  = 1'b0;
        known_o = 1'b0;
        case (size_i)
            SZ_BYTE, SZ_HALF, SZ_WORD: begin
                s_o     = src_sg_i[size_i];
                d_o     = dst_sg_i[size_i];
                r_o     = res_sg[size_i];
                zero_o  = res_zero[size_i];
                known_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ccf_arith_rule.sv
module ccf_arith_rule
    import ccf_pkg::*;
(
    input  logic       s_i,
    input  logic       d_i,
    input  logic       r_i,
    input  logic       zero_i,
    input  logic       known_i,
    input  logic       flip_src_i,
    input  logic       flip_carry_i,
    output ccf_flags_t flags_o
);
    logic s_eff;

    always_comb begin
        s_eff   = s_i ^ flip_src_i;
        flags_o = '0;
        if (known_i) begin
            if (r_i) begin
                flags_o.n = 1'b1;
                if (!s_eff && !d_i) begin
                    flags_o.v = 1'b1;
                end else if (s_eff && d_i) begin
                    flags_o.c = 1'b1;
                end
            end else begin
                flags_o.z = zero_i;
                flags_o.v = s_eff & d_i;
                flags_o.c = s_eff | d_i;
            end
        end
        flags_o.c = flags_o.c ^ flip_carry_i;
    end
endmodule

// File: rtl/ccf_mul_rule.sv
module ccf_mul_rule #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic              signed_i,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o
);
    logic wide_zero;
    logic hi_is_ext;

    always_comb begin
        wide_zero = ~|{hi_i, lo_i};
        hi_is_ext = (hi_i == {DATA_W{lo_i[DATA_W-1]}});
        z_o       = wide_zero;
        n_o       = !wide_zero && hi_i[DATA_W-1];
        v_o       = signed_i ? !hi_is_ext : |hi_i;
    end
endmodule

// File: rtl/ccf_merge.sv
module ccf_merge
    import ccf_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int R_POS  = 8
) (
    input  logic [STAT_W-1:0] ccs_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              x_i,
    input  ccf_flags_t        flags_i,
    input  logic              carry_to_r_i,
    input  logic              hold_i,
    output logic [STAT_W-1:0] ccs_o
);
    logic [STAT_W-1:0] new_bits;
    logic [STAT_W-1:0] wr_mask;

    always_comb begin
        new_bits        = '0;
        new_bits[N_POS] = flags_i.n;
        new_bits[Z_POS] = flags_i.z;
        new_bits[V_POS] = flags_i.v;
        if (carry_to_r_i) begin
            new_bits[R_POS] = flags_i.c;
        end else begin
            new_bits[C_POS] = flags_i.c;
        end

        wr_mask        = mask_i;
        wr_mask[X_POS] = 1'b1;
        if (x_i && flags_i.z) begin
            wr_mask[Z_POS] = 1'b0;
        end

        if (hold_i) begin
            ccs_o = ccs_i;
        end else begin
            ccs_o = (ccs_i & ~wr_mask) | (new_bits & wr_mask);
        end
    end
endmodule

// File: rtl/ccf_eval.sv
module ccf_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAT_W = 32,
    parameter int R_POS  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              x_i,
    input  logic [STAT_W-1:0] ccs_i,
    output logic [STAT_W-1:0] ccs_o
);
    typedef struct packed {
        logic [STAT_W-1:0] ccs;
    } state_t;

    state_t state_d, state_q;

    ccf_op_e   op;
    ccf_size_e eff_size;
    logic      is_sub, is_mcp, is_mul, is_nz_only, is_live;

    logic [NLANE-1:0] src_sg, dst_sg;
    logic s_bit, d_bit, r_bit, zero_bit, known;
    logic mul_n, mul_z, mul_v;
    ccf_flags_t arith_flags, sel_flags;
    logic [STAT_W-1:0] merged;

    // sign taps at each supported width
    for (genvar g = 0; g < NLANE; g++) begin : g_tap
        localparam int TW = ((8 << g) > DATA_W) ? DATA_W : (8 << g);
        assign src_sg[g] = src_i[TW-1];
        assign dst_sg[g] = dst_i[TW-1];
    end

    always_comb begin
        op         = ccf_op_e'(op_i);
        is_sub     = (op == OPC_SUB) || (op == OPC_CMP);
        is_mcp     = (op == OPC_MCP);
        is_mul     = (op == OPC_MULS) || (op == OPC_MULU);
        is_live    = (op == OPC_LIVE);
        is_nz_only = (op == OPC_LOGIC) &&
                     ((size_i == SZ_HALF) || (size_i == SZ_WORD));
        eff_size   = is_mcp ? SZ_WORD : ccf_size_e'(size_i);
    end

    ccf_lane_view #(.DATA_W(DATA_W)) u_view (
        .size_i   (eff_size),
        .src_sg_i (src_sg),
        .dst_sg_i (dst_sg),
        .res_i    (res_i),
        .s_o      (s_bit),
        .d_o      (d_bit),
        .r_o      (r_bit),
        .zero_o   (zero_bit),
        .known_o  (known)
    );

    ccf_arith_rule u_arith (
        .s_i          (s_bit),
        .d_i          (d_bit),
        .r_i          (r_bit),
        .zero_i       (zero_bit),
        .known_i      (known),
        .flip_src_i   (is_sub),
        .flip_carry_i (is_sub),
        .flags_o      (arith_flags)
    );

    ccf_mul_rule #(.DATA_W(DATA_W)) u_mul (
        .hi_i     (hi_i),
        .lo_i     (res_i),
        .signed_i (op == OPC_MULS),
        .n_o      (mul_n),
        .z_o      (mul_z),
        .v_o      (mul_v)
    );

    always_comb begin
        if (is_mul) begin
            sel_flags = '{n: mul_n, z: mul_z, v: mul_v, c: 1'b0};
        end else if (is_nz_only) begin
            sel_flags = '{n: r_bit, z: !r_bit && zero_bit, v: 1'b0, c: 1'b0};
        end else begin
            sel_flags = arith_flags;
        end
    end

    ccf_merge #(.STAT_W(STAT_W), .R_POS(R_POS)) u_merge (
        .ccs_i        (ccs_i),
        .mask_i       (mask_i),
        .x_i          (x_i),
        .flags_i      (sel_flags),
        .carry_to_r_i (is_mcp),
        .hold_i       (is_live),
        .ccs_o        (merged)
    );

    always_comb begin
        state_d     = state_q;
        state_d.ccs = merged;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ccs_o = state_q.ccs;

    // R12: flags-live class passes the status word through
    a_r12_live_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd7) |=> (ccs_o == $past(ccs_i)));

    // R10: every evaluating class leaves X clear
    a_r10_x_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i != 3'd7) |=> !ccs_o[X_POS]);

    // R11: sticky zero in extended mode
    a_r11_zero_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i != 3'd7 && x_i && !ccs_i[Z_POS]) |=> !ccs_o[Z_POS]);

    // R2: N and Z never both freshly written
    a_r2_n_z_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i != 3'd7 && !x_i && mask_i[N_POS] && mask_i[Z_POS])
        |=> !(ccs_o[N_POS] && ccs_o[Z_POS]));

    // R8: unsigned product with nonzero high word overflows
    a_r8_mulu_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd5 && mask_i[V_POS] && hi_i != '0) |=> ccs_o[V_POS]);

    // R9: logic class at wide sizes never writes C or V as 1
    a_r9_logic_no_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd6 && size_i inside {2'd1, 2'd2} && mask_i[C_POS] && mask_i[V_POS])
        |=> (!ccs_o[C_POS] && !ccs_o[V_POS]));

    // R1: reset clears the output register
    a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> (ccs_o == '0));

endmodule

// File: tb/tb_ccf_eval.sv
module tb_ccf_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] src = '0, dst = '0, res = '0, hi = '0, mask = '0, ccs_in = '0;
    logic        x = 1'b0;
    logic [31:0] ccs_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    ccf_eval dut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .size_i(size),
        .src_i(src), .dst_i(dst), .res_i(res), .hi_i(hi),
        .mask_i(mask), .x_i(x), .ccs_i(ccs_in), .ccs_o(ccs_out)
    );

    function automatic logic [31:0] model(int o, int sz, logic [31:0] s, logic [31:0] d,
                                          logic [31:0] r, logic [31:0] h, logic [31:0] m,
                                          logic xx, logic [31:0] c);
        logic fn = 0, fz = 0, fv = 0, fc = 0;
        logic ss, ds, rs, zz;
        logic [31:0] sx, nv, wm;
        int w, esz;
        if (o == 7) return c;
        if (o == 4 || o == 5) begin
            zz = ({h, r} == 64'd0);
            fz = zz;
            fn = !zz && h[31];
            fv = (o == 4) ? (h != {32{r[31]}}) : (h != 0);
        end else begin
            esz = (o == 3) ? 2 : sz;
            w = (esz == 0) ? 8 : (esz == 1) ? 16 : (esz == 2) ? 32 : 0;
            if (w != 0) begin
                sx = (o == 1 || o == 2) ? ~s : s;
                ss = sx[w-1];
                ds = d[w-1];
                rs = r[w-1];
                zz = ((r << (32 - w)) == 0);
                if (o == 6 && w > 8) begin
                    fn = rs;
                    fz = !rs && zz;
                end else if (rs) begin
                    fn = 1;
                    if (!ss && !ds) fv = 1;
                    else if (ss && ds) fc = 1;
                end else begin
                    fz = zz;
                    fv = ss && ds;
                    fc = ss || ds;
                end
            end
            if (o == 1 || o == 2) fc = !fc;
        end
        nv = 0;
        nv[3] = fn; nv[2] = fz; nv[1] = fv;
        if (o == 3) nv[8] = fc; else nv[0] = fc;
        wm = m | 32'h10;
        if (xx && fz) wm[2] = 0;
        return (c & ~wm) | (nv & wm);
    endfunction

    task automatic drv(int o, int sz, logic [31:0] s, logic [31:0] d, logic [31:0] r,
                       logic [31:0] h, logic [31:0] m, logic xx, logic [31:0] c,
                       logic [31:0] exp, string tag);
        item_t it;
        @(negedge clk);
        op = o[2:0]; size = sz[1:0];
        src = s; dst = d; res = r; hi = h; mask = m; x = xx; ccs_in = c;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: result registered at the edge after the drive
    always @(posedge clk) begin
        item_t it;
        #2;
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (ccs_out !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, ccs_out, it.exp);
            end
        end
    end

    function automatic string tag_of(int o);
        case (o)
            0: return "R2";
            1, 2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h0000_0080 << ($urandom_range(0, 3) * 8);
            2: return 32'hFFFF_FFFF;
            3: return {24'h0, 8'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        src = 32'hFFFF_FFFF; ccs_in = 32'hFFFF_FFFF; mask = 32'hF; op = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (ccs_out !== 32'h0) begin
            fails++;
            $display("FAIL R1 reset actual=%h expected=%h", ccs_out, 32'h0);
        end
        rst_n = 1'b1;

        // R2: negative result
        drv(0, 2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 32'hF, 0, 0, 32'hA, "R2");
        drv(0, 2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 0, 32'hF, 0, 0, 32'h9, "R2");
        // R3: zero result with both signs set
        drv(0, 2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'hF, 0, 0, 32'h7, "R3");
        drv(0, 2, 32'h0, 32'h8000_0000, 32'h5, 0, 32'hF, 0, 0, 32'h1, "R3");
        // R4: width selection and the no-width code
        drv(0, 0, 32'hFFFF_FF7F, 32'h1, 32'h0000_0080, 0, 32'hF, 0, 0, 32'hA, "R4");
        drv(0, 1, 32'h0, 32'h0, 32'h0001_0000, 0, 32'hF, 0, 0, 32'h4, "R4");
        drv(0, 3, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'hF, 0, 32'hF, 32'h0, "R4");
        drv(1, 3, 32'h0, 32'h0, 32'h0, 0, 32'hF, 0, 0, 32'h1, "R4");
        // R5: subtract inversions
        drv(1, 2, 32'h1, 32'h1, 32'h0, 0, 32'hF, 0, 0, 32'h4, "R5");
        drv(2, 2, 32'h1, 32'h0, 32'hFFFF_FFFF, 0, 32'hF, 0, 0, 32'h9, "R5");
        // R6: multiply-carry into R, always word width
        drv(3, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'h10F, 0, 32'h1, 32'h106, "R6");
        // R7: signed multiply
        drv(4, 2, 0, 0, 32'h8000_0000, 32'h0, 32'hF, 0, 0, 32'h2, "R7");
        drv(4, 2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hF, 0, 0, 32'h8, "R7");
        drv(4, 2, 0, 0, 32'h0, 32'h0, 32'hF, 0, 32'hB, 32'h4, "R7");
        // R8: unsigned multiply
        drv(5, 2, 0, 0, 32'h0, 32'h1, 32'hF, 0, 0, 32'h2, "R8");
        drv(5, 2, 0, 0, 32'h0, 32'h8000_0000, 32'hF, 0, 0, 32'hA, "R8");
        // R9: logic class
        drv(6, 2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 0, 32'hF, 0, 0, 32'h8, "R9");
        drv(6, 1, 32'h0, 32'h0, 32'h0000_8000, 0, 32'hF, 0, 0, 32'h8, "R9");
        drv(6, 0, 32'h80, 32'h80, 32'h80, 0, 32'hF, 0, 0, 32'h9, "R9");
        // R10: mask and X clearing
        drv(0, 2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'h3, 0, 32'h10, 32'h3, "R10");
        drv(0, 2, 32'h1, 32'h1, 32'h2, 0, 32'h0, 0, 32'hA5A5_0018, 32'hA5A5_0008, "R10");
        // R11: sticky zero
        drv(0, 2, 32'h0, 32'h0, 32'h0, 0, 32'hF, 1, 32'h0, 32'h0, "R11");
        drv(0, 2, 32'h0, 32'h0, 32'h1, 0, 32'hF, 1, 32'h4, 32'h0, "R11");
        drv(0, 2, 32'h0, 32'h0, 32'h0, 0, 32'hF, 1, 32'h4, 32'h4, "R11");
        // R12: live flags
        drv(7, 2, 32'h8000_0000, 32'h0, 32'h0, 0, 32'hFFFF_FFFF, 1, 32'h1234_5678, 32'h1234_5678, "R12");

        // random sweep over every class and width
        for (int o = 0; o < 8; o++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int k = 0; k < 30; k++) begin
                    logic [31:0] s = pick(), d = pick(), r = pick(), h = pick();
                    logic [31:0] m = $urandom | 32'h0000_0100;
                    logic [31:0] c = $urandom;
                    logic xx = 1'($urandom);
                    drv(o, sz, s, d, r, h, m, xx, c, model(o, sz, s, d, r, h, m, xx, c), tag_of(o));
                end
            end
        end

        repeat (4) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule